// File: doc/BRIEF.md
# Eight-Channel Match Timer Array

This block holds eight extended timer channels, numbered 4 to 11 (internal index 0 to 7). Each channel has a 32-bit counter, a 32-bit match value and a control word. The control word sets four things: which of five external tick-enable pulses advances the counter, whether the channel counts alone or follows the counter of its group leader, whether a match clears the counter, and whether the channel re-arms after a match. The group leaders are channels 4, 8 and 10.

Software reaches the registers through a simple synchronous register port. Writes take effect on the clock edge. Reads are combinational from the address. Reading the counter of channel 9 or 11 can latch the counter of the channel before it into a snapshot register, so that two counters are captured together.

Each match sets a status bit if its enable input is high. The enables and the clear strobes come from a shared register file that sits beside this block. A single interrupt line covers all eight channels.

Top module: `match_timer_array`

## Requirements
- R1: After reset, every counter, match value, control word, the snapshot and all status bits read zero, and `irq` is low.
- R2: Byte addresses are fixed: counter of index i at 0x40+4i, match value at 0x80+4i, control word at 0xC0+4i, snapshot at 0x20. Other addresses read zero. Control words of indices 0 to 3 keep bits [7:0]. Those of indices 4 to 7 keep bits [9:0].
- R3: Control bits [2:0] pick the tick. Values 1, 2, 3, 4 and 5 select `tick_in[0]` to `tick_in[4]`. Values 0, 6 and 7 mean no clock. A counter advances by one per cycle in which its tick is high, and holds its value when it has no clock.
- R4: On indices 4 to 7, control bit 8 set forces no clock.
- R5: Bit 7 set makes a channel count on its own. With bit 7 clear, a channel that is not a leader gets no tick. It compares against its leader's counter instead: indices 0 to 3 use index 0, indices 4 and 5 use index 4, and indices 6 and 7 use index 6.
- R6: A match happens when the compared counter steps, on a tick, to the channel's match value. It sets status bit i only when `irq_en[i]` is high.
- R7: With control bit 3 set, a match loads the channel's own counter with zero instead of the stepped value.
- R8: With control bit 6 set, the channel stays armed after a match. With bit 6 clear, it ignores further matches until its match value or control word is written.
- R9: A read of the counter of index 5 or 7 while that channel's control bit 9 is set copies the counter of index 4 or 6 into the snapshot. Any other read leaves the snapshot unchanged.
- R10: `irq` is high while any status bit is set. A `sts_clr` bit clears its status bit, and a new match in the same cycle takes priority.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (drives snapshot capture) |
| addr | input | 8 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from `addr` |
| tick_in | input | 5 | Tick enables: 32.768 kHz, 1 kHz, 1 Hz, 1 MHz, external |
| irq_en | input | 8 | Match interrupt enables for indices 0 to 7 |
| sts_clr | input | 8 | Write-one-to-clear strobes for status |
| status | output | 8 | Match status for indices 0 to 7 |
| irq | output | 1 | Combined interrupt |

## Verification
A wrong tick selection or a wrong leader mapping shows up as a counter read-back that differs from the number of selected pulses, one cycle after the last pulse. A bad match compare, or a stuck one-shot flag, appears on `status` and `irq` in the cycle after the stepping tick. It also shows on the counter, which reads zero or does not. A snapshot captured from the wrong source, or on the wrong condition, is visible on the first read of 0x20 after the triggering counter read.

// File: rtl/match_timer_array.sv
module match_timer_array #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         rd_en,
  input  logic [7:0]   addr,
  input  logic [31:0]  wdata,
  output logic [31:0]  rdata,
  input  logic [4:0]   tick_in,
  input  logic [7:0]   irq_en,
  input  logic [7:0]   sts_clr,
  output logic [7:0]   status,
  output logic         irq
);
  localparam int NCH = 8;

  logic [W-1:0] cnt [NCH];
  logic [W-1:0] mat [NCH];
  logic [9:0]   ctl [NCH];
  logic [NCH-1:0] tk, hit, fired, cnt_wr, mat_wr, ctl_wr;
  logic [W-1:0] snap;

  assign irq = |status;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam int LEAD = (i < 4) ? 0 : (i < 6) ? 4 : 6;
    localparam bit IS_LEAD = (i == LEAD);
    logic       own;
    logic [2:0] sel;
    logic       raw;

    assign cnt_wr[i] = wr_en && addr == 8'(8'h40 + 4*i);
    assign mat_wr[i] = wr_en && addr == 8'(8'h80 + 4*i);
    assign ctl_wr[i] = wr_en && addr == 8'(8'hC0 + 4*i);
    assign own = ctl[i][7] || IS_LEAD;
    assign sel = (i >= 4 && ctl[i][8]) ? 3'd0 : ctl[i][2:0];

    always_comb begin
      tk[i] = 1'b0;
      if (own && sel >= 3'd1 && sel <= 3'd5) tk[i] = tick_in[sel - 3'd1];
    end

    if (IS_LEAD) begin : g_self
      assign raw = tk[i] && !cnt_wr[i] && (cnt[i] + 1'b1 == mat[i]);
    end else begin : g_follow
      assign raw = own ? (tk[i] && !cnt_wr[i] && (cnt[i] + 1'b1 == mat[i]))
                       : (tk[LEAD] && !cnt_wr[LEAD] && (cnt[LEAD] + 1'b1 == mat[i]));
    end
    assign hit[i] = raw && !fired[i];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt[i] <= '0; mat[i] <= '0; ctl[i] <= '0;
        fired[i] <= 1'b0; status[i] <= 1'b0;
      end else begin
        if (cnt_wr[i])                   cnt[i] <= wdata[W-1:0];
        else if (hit[i] && ctl[i][3])    cnt[i] <= '0;
        else if (tk[i])                  cnt[i] <= cnt[i] + 1'b1;
        if (mat_wr[i]) mat[i] <= wdata[W-1:0];
        if (ctl_wr[i]) ctl[i] <= (i < 4) ? {2'b00, wdata[7:0]} : wdata[9:0];
        if (mat_wr[i] || ctl_wr[i])      fired[i] <= 1'b0;
        else if (hit[i] && !ctl[i][6])   fired[i] <= 1'b1;
        if (hit[i] && irq_en[i])         status[i] <= 1'b1;
        else if (sts_clr[i])             status[i] <= 1'b0;
      end
    end

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (!tk[i] && !cnt_wr[i] && !hit[i]) |=> $stable(cnt[i])); // R3
    AST_STATUS_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[i]) |-> $past(irq_en[i])); // R6
    AST_ONESHOT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (fired[i] && !mat_wr[i] && !ctl_wr[i]) |=> !$rose(status[i])); // R8
    AST_CLEAR_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[i] && ctl[i][3] && !cnt_wr[i]) |=> cnt[i] == '0); // R7
  end

  always_ff @(posedge clk) begin
    if (!rst_n) snap <= '0;
    else if (rd_en && addr == 8'h54 && ctl[5][9]) snap <= cnt[4];
    else if (rd_en && addr == 8'h5C && ctl[7][9]) snap <= cnt[6];
  end

  always_comb begin
    rdata = '0;
    if (addr == 8'h20) rdata = 32'(snap);
    for (int k = 0; k < NCH; k++) begin
      if (addr == 8'(8'h40 + 4*k)) rdata = 32'(cnt[k]);
      if (addr == 8'(8'h80 + 4*k)) rdata = 32'(mat[k]);
      if (addr == 8'(8'hC0 + 4*k)) rdata = 32'(ctl[k]);
    end
  end

  AST_SNAP_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(snap) |-> $past(rd_en)); // R9
  AST_IRQ_DROPS_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(|sts_clr)); // R10
endmodule

// File: tb/match_timer_array_bench.sv
module match_timer_array_bench;
  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [7:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic [4:0] tick_in = 0;
  logic [7:0] irq_en = 0, sts_clr = 0, status;
  logic irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  match_timer_array u_match_timer_array (.*);

  function automatic logic [31:0] exp_cnt(logic [31:0] start, int n);
    return start + 32'(n);
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd_en = 1; #1 d = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic pulse(logic [4:0] m, int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick_in = m;
      @(negedge clk); tick_in = 0;
    end
  endtask

  task automatic clr(logic [7:0] m);
    @(negedge clk); sts_clr = m;
    @(negedge clk); sts_clr = 0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int i = 0; i < 8; i++) begin
      rd(8'(8'h40 + 4*i), v); chk("R1 cnt", v, 0);
      rd(8'(8'hC0 + 4*i), v); chk("R1 ctl", v, 0);
    end
    rd(8'h20, v); chk("R1 snap", v, 0);
    chk("R1 irq/status", {23'b0, irq, status}, 0);

    // R2 map and control masks
    wr(8'h80, 32'hDEADBEEF); rd(8'h80, v); chk("R2 match", v, 32'hDEADBEEF);
    wr(8'hC0, 32'hFFFFFFFF); rd(8'hC0, v); chk("R2 ctl mask low", v, 32'hFF);
    wr(8'hD0, 32'hFFFFFFFF); rd(8'hD0, v); chk("R2 ctl mask high", v, 32'h3FF);
    rd(8'h3C, v); chk("R2 unmapped", v, 0);

    // R3 no clock holds
    wr(8'hC0, 32'h80); wr(8'h40, 32'h77); pulse(5'h1F, 3);
    rd(8'h40, v); chk("R3 hold", v, 32'h77);

    // R3 random tick selection
    for (int it = 0; it < 25; it++) begin
      int i, sel, n;
      logic [31:0] st;
      i = $urandom % 8; sel = 1 + $urandom % 5; st = $urandom & 32'h7FFFFFFF; n = 0;
      wr(8'(8'h80 + 4*i), 0);
      wr(8'(8'hC0 + 4*i), 32'(32'h80 | sel));
      wr(8'(8'h40 + 4*i), st);
      for (int p = 0; p < 1 + $urandom % 8; p++) begin
        logic [4:0] m;
        m = 5'($urandom);
        if (m[sel-1]) n++;
        pulse(m, 1);
      end
      rd(8'(8'h40 + 4*i), v); chk("R3 count", v, exp_cnt(st, n));
    end

    // R4 force no clock on upper channels
    wr(8'hD8, 32'h181); wr(8'h58, 50); pulse(5'h01, 3);
    rd(8'h58, v); chk("R4 forced off", v, 50);
    wr(8'hD8, 32'h81); pulse(5'h01, 3);
    rd(8'h58, v); chk("R4 released", v, 53);

    // R5 follower compares against leader
    for (int i = 0; i < 8; i++) wr(8'(8'h80 + 4*i), 32'hFFFF0000);
    irq_en = 8'h02;
    wr(8'hC0, 32'h81); wr(8'h40, 0);
    wr(8'hC4, 32'h00); wr(8'h44, 7); wr(8'h84, 2);
    pulse(5'h01, 2);
    chk("R5 follower status", {24'b0, status}, 8'h02);
    rd(8'h44, v); chk("R5 follower frozen", v, 7);
    rd(8'h40, v); chk("R5 leader", v, 2);
    clr(8'h02);
    chk("R10 cleared", {31'b0, irq}, 0);

    // R6 disabled match sets no status
    irq_en = 0;
    wr(8'hC0, 32'hC1); wr(8'h40, 0); wr(8'h80, 2); pulse(5'h01, 2);
    chk("R6 disabled", {24'b0, status}, 0);

    // R7/R8 one-shot with clear on match
    irq_en = 8'h01;
    wr(8'hC0, 32'h89); wr(8'h40, 0); wr(8'h80, 3);
    pulse(5'h01, 3);
    chk("R6 status set", {24'b0, status}, 8'h01);
    chk("R10 irq high", {31'b0, irq}, 1);
    rd(8'h40, v); chk("R7 clear", v, 0);
    clr(8'h01);
    chk("R10 irq low", {31'b0, irq}, 0);
    pulse(5'h01, 3);
    chk("R8 one-shot quiet", {24'b0, status}, 0);
    rd(8'h40, v); chk("R8 one-shot count", v, 3);

    // R8 periodic
    wr(8'hC0, 32'hC9); wr(8'h40, 0);
    pulse(5'h01, 3);
    chk("R8 periodic 1", {24'b0, status}, 8'h01);
    clr(8'h01);
    pulse(5'h01, 3);
    chk("R8 periodic 2", {24'b0, status}, 8'h01);
    rd(8'h40, v); chk("R7 periodic clear", v, 0);
    // R10 set wins over same-cycle clear
    clr(8'h01); pulse(5'h01, 2);
    @(negedge clk); tick_in = 5'h01; sts_clr = 8'h01;
    @(negedge clk); tick_in = 0; sts_clr = 0;
    chk("R10 set priority", {24'b0, status}, 8'h01);
    clr(8'h01); irq_en = 0;

    // R9 snapshot
    wr(8'hD0, 32'h81); wr(8'h50, 100); wr(8'hD4, 32'h200);
    pulse(5'h01, 5);
    rd(8'h54, v); rd(8'h20, v); chk("R9 capture", v, 105);
    wr(8'hD4, 32'h000); pulse(5'h01, 2);
    rd(8'h54, v); rd(8'h20, v); chk("R9 no capture", v, 105);
    rd(8'h50, v); chk("R9 source", v, 107);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule